// File: doc/BRIEF.md
# SPI Memory Command Front-End

This block is the serial receive and transmit front-end of a memory device that is always the slave on an SPI bus. It runs in a local system clock domain. The bus pins (serial clock, active-low select, serial data in, active-low pause) are brought in through synchronizers, and their edges are detected in that domain. The bus clock is only ever an input. The block uses SPI mode 0: it samples serial data in on the rising bus-clock edge and changes serial data out on the falling edge, most significant bit first.

After each selection, the first complete byte is taken as the command code and checked against a fixed set of supported codes. After an accepted code, each further byte is handed to downstream logic with a one-cycle strobe. For read-type codes, the block drives its serial output from a byte that downstream logic supplies, and pulses an acknowledge each time it takes that byte. An unsupported code locks the block out until the next selection. The pause input freezes a transfer in progress without losing its position, but only when it changes while the bus clock is low.

Top module: `spi_cmd_frontend`

## Requirements
- R1: While selected (`spi_cs_n` low) and not paused, each rising `spi_sck` edge shifts `spi_si` into the receive register MSB first. Every falling edge of `spi_cs_n` restarts the bit count, so a byte cut short by deselection is discarded.
- R2: The first 8 bits after selection form `opcode`. The codes 8'h01, 8'h02, 8'h03, 8'h04, 8'h05 and 8'h06 set `cmd_ok`. Any other value sets `cmd_bad`. The two flags are never high together, and both clear on the next falling edge of `spi_cs_n`.
- R3: After an accepted code, each further complete byte appears on `rx_data` with `rx_stb` high for exactly one clock.
- R4: After an unsupported code, no byte is strobed and `spi_so_oe` stays low until the next falling edge of `spi_cs_n`. The selection that follows is decoded normally.
- R5: `spi_so_oe` is high only while selected, not paused, and after an accepted read-type code (8'h03 or 8'h05). `spi_so` presents `tx_data` MSB first. The block loads a byte on the first falling `spi_sck` edge after each byte boundary, pulses `tx_take` for one clock, and changes `spi_so` on no other event.
- R6: A falling edge of `spi_hold_n` while `spi_sck` is low pauses the transfer. While paused, `spi_sck` edges neither shift data nor count bits, and `spi_so_oe` is low. A rising edge of `spi_hold_n` while `spi_sck` is low resumes the transfer at the same bit.
- R7: A falling edge of `spi_hold_n` while `spi_sck` is high does not pause the transfer.
- R8: While `spi_cs_n` is high, `spi_sck` and `spi_si` activity produces no strobe, leaves `opcode` unchanged and keeps `spi_so_oe` low.
- R9: After reset, `spi_so_oe`, `rx_stb`, `cmd_ok`, `cmd_bad` and `tx_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | Bus serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data from the master |
| spi_hold_n | input | 1 | Active-low pause request |
| tx_data | input | 8 | Byte to be shifted out on read-type commands |
| spi_so | output | 1 | Serial data to the master |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| opcode | output | 8 | Last command code received |
| cmd_ok | output | 1 | Command code is supported |
| cmd_bad | output | 1 | Command code is unsupported (lockout) |
| rx_data | output | 8 | Last data byte received after the code |
| rx_stb | output | 1 | One-clock strobe for `rx_data` |
| tx_take | output | 1 | One-clock pulse when `tx_data` was loaded |

## Verification
The bench pauses a read mid-byte and toggles the bus clock with garbage on the data line during the pause. A design that kept counting would then return a shifted receive byte and a misaligned output byte, and one that left its pad enabled would be caught by the enable check. The bench also drops the pause input while the bus clock is high and expects an unbroken byte, which catches a design that treats every pause edge as valid. An unsupported code followed by more bytes must produce no strobe and a clean next selection, so a design that ignores the lockout or never clears it fails. A selection aborted mid-byte must not leave stale bits in the next code.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  bcnt_t;

  localparam byte_t OP_STAT_WR = 8'h01;
  localparam byte_t OP_MEM_WR  = 8'h02;
  localparam byte_t OP_MEM_RD  = 8'h03;
  localparam byte_t OP_WR_DIS  = 8'h04;
  localparam byte_t OP_STAT_RD = 8'h05;
  localparam byte_t OP_WR_EN   = 8'h06;

  typedef enum logic [1:0] {
    FE_IDLE,
    FE_OPC,
    FE_DATA,
    FE_LOCK
  } fe_state_e;

  function automatic logic op_known(byte_t op);
    case (op)
      OP_STAT_WR, OP_MEM_WR, OP_MEM_RD,
      OP_WR_DIS, OP_STAT_RD, OP_WR_EN: return 1'b1;
      default:                         return 1'b0;
    endcase
  endfunction

  function automatic logic op_reads(byte_t op);
    return (op == OP_MEM_RD) || (op == OP_STAT_RD);
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl
);

  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign lvl = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck_lvl,
  input  logic hold_rise,
  input  logic hold_fall,
  output logic held
);

  logic held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (!sel)                       held_d = 1'b0;
    else if (hold_fall && !sck_lvl) held_d = 1'b1;
    else if (hold_rise && !sck_lvl) held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign held = held_q;

  AST_HOLD_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> !$past(sck_lvl)); // R6

  AST_HOLD_HIGH_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_fall && sck_lvl && !held_q) |=> !held_q); // R7

  AST_HOLD_DROPS_ON_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !held_q); // R8

endmodule

// File: rtl/spi_fe_cmd.sv
module spi_fe_cmd
  import spi_fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  cs_fall,
  input  logic  sck_rise,
  input  logic  si_lvl,
  input  logic  held,
  output byte_t opcode,
  output logic  cmd_ok,
  output logic  cmd_bad,
  output logic  rd_mode,
  output byte_t rx_data,
  output logic  rx_stb,
  output bcnt_t bit_cnt
);

  localparam bcnt_t LAST_BIT = bcnt_t'(BYTE_W - 1);

  fe_state_e st_q, st_d;
  bcnt_t     cnt_q, cnt_d;
  byte_t     sr_q, sr_d, op_q, op_d, rxd_q, rxd_d, byte_nx;
  logic      ok_q, ok_d, bad_q, bad_d, rd_q, rd_d, stb_q, stb_d;
  logic      shift_en;

  assign shift_en = sel && !held && sck_rise &&
                    ((st_q == FE_OPC) || (st_q == FE_DATA));
  assign byte_nx  = {sr_q[BYTE_W-2:0], si_lvl};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sr_d  = sr_q;
    op_d  = op_q;
    rxd_d = rxd_q;
    ok_d  = ok_q;
    bad_d = bad_q;
    rd_d  = rd_q;
    stb_d = 1'b0;
    if (cs_fall) begin
      st_d  = FE_OPC;
      cnt_d = '0;
      ok_d  = 1'b0;
      bad_d = 1'b0;
      rd_d  = 1'b0;
    end else if (shift_en) begin
      sr_d  = byte_nx;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        if (st_q == FE_OPC) begin
          op_d = byte_nx;
          if (op_known(byte_nx)) begin
            st_d = FE_DATA;
            ok_d = 1'b1;
            rd_d = op_reads(byte_nx);
          end else begin
            st_d  = FE_LOCK;
            bad_d = 1'b1;
          end
        end else begin
          rxd_d = byte_nx;
          stb_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FE_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
      op_q  <= '0;
      rxd_q <= '0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
      rd_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      op_q  <= op_d;
      rxd_q <= rxd_d;
      ok_q  <= ok_d;
      bad_q <= bad_d;
      rd_q  <= rd_d;
      stb_q <= stb_d;
    end
  end

  assign opcode  = op_q;
  assign cmd_ok  = ok_q;
  assign cmd_bad = bad_q;
  assign rd_mode = rd_q && (st_q == FE_DATA);
  assign rx_data = rxd_q;
  assign rx_stb  = stb_q;
  assign bit_cnt = cnt_q;

  AST_OK_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && bad_q)); // R2

  AST_OK_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> op_known(op_q)); // R2

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R3

  AST_LOCK_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FE_LOCK) |=> !stb_q); // R4

  AST_HOLD_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_fall) |=> $stable(cnt_q)); // R6

  AST_DESEL_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !cs_fall) |=> ($stable(op_q) && !stb_q)); // R8

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
  import spi_fe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_fall,
  input  logic  active,
  input  logic  rd_mode,
  input  bcnt_t bit_cnt,
  input  byte_t tx_data,
  output logic  so,
  output logic  so_oe,
  output logic  tx_take
);

  byte_t txsr_q, txsr_d;
  logic  take_q, take_d;
  logic  step_en;

  assign step_en = sck_fall && active && rd_mode;

  always_comb begin
    txsr_d = txsr_q;
    take_d = 1'b0;
    if (step_en) begin
      if (bit_cnt == '0) begin
        txsr_d = tx_data;
        take_d = 1'b1;
      end else begin
        txsr_d = {txsr_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr_q <= '0;
      take_q <= 1'b0;
    end else begin
      txsr_q <= txsr_d;
      take_q <= take_d;
    end
  end

  assign so      = txsr_q[BYTE_W-1];
  assign so_oe   = rd_mode && active;
  assign tx_take = take_q;

  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(txsr_q)); // R5

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q); // R5

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_si,
  input  logic       spi_hold_n,
  input  logic [7:0] tx_data,
  output logic       spi_so,
  output logic       spi_so_oe,
  output logic [7:0] opcode,
  output logic       cmd_ok,
  output logic       cmd_bad,
  output logic [7:0] rx_data,
  output logic       rx_stb,
  output logic       tx_take
);

  // pin vector layout: {hold_n, si, cs_n, sck}
  localparam int        PIN_W   = 4;
  localparam int        CTL_W   = 3;
  localparam logic [PIN_W-1:0] PIN_RST = 4'b1010;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_W-1:0] pin_lvl;
  logic [CTL_W-1:0] ctl_prev_q, ctl_lvl;
  logic             sck_lvl, cs_lvl, si_lvl, hold_lvl;
  logic             sck_rise, sck_fall, cs_fall, hold_rise, hold_fall;
  logic             sel, held, rd_mode;
  bcnt_t            bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spi_fe_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
    .lvl      (pin_lvl)
  );

  assign sck_lvl  = pin_lvl[0];
  assign cs_lvl   = pin_lvl[1];
  assign si_lvl   = pin_lvl[2];
  assign hold_lvl = pin_lvl[3];
  assign ctl_lvl  = {hold_lvl, cs_lvl, sck_lvl};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctl_prev_q <= 3'b110;
    else            ctl_prev_q <= ctl_lvl;
  end

  assign sck_rise  =  sck_lvl  && !ctl_prev_q[0];
  assign sck_fall  = !sck_lvl  &&  ctl_prev_q[0];
  assign cs_fall   = !cs_lvl   &&  ctl_prev_q[1];
  assign hold_rise =  hold_lvl && !ctl_prev_q[2];
  assign hold_fall = !hold_lvl &&  ctl_prev_q[2];
  assign sel       = !cs_lvl;

  spi_fe_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel       (sel),
    .sck_lvl   (sck_lvl),
    .hold_rise (hold_rise),
    .hold_fall (hold_fall),
    .held      (held)
  );

  spi_fe_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel      (sel),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .si_lvl   (si_lvl),
    .held     (held),
    .opcode   (opcode),
    .cmd_ok   (cmd_ok),
    .cmd_bad  (cmd_bad),
    .rd_mode  (rd_mode),
    .rx_data  (rx_data),
    .rx_stb   (rx_stb),
    .bit_cnt  (bit_cnt)
  );

  spi_fe_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck_fall (sck_fall),
    .active   (sel && !held),
    .rd_mode  (rd_mode),
    .bit_cnt  (bit_cnt),
    .tx_data  (tx_data),
    .so       (spi_so),
    .so_oe    (spi_so_oe),
    .tx_take  (tx_take)
  );

  AST_OE_NEEDS_GOOD_CODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    spi_so_oe |-> (cmd_ok && op_reads(opcode))); // R5

  AST_OE_OFF_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    held |-> !spi_so_oe); // R6

  AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_lvl |-> !spi_so_oe); // R8

  AST_LOCK_NO_OE: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_bad |-> !spi_so_oe); // R4

endmodule

// File: tb/spi_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_frontend_tb_top;

  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sck, cs_n, si, hold_n;
  logic [7:0] tx_base;
  logic [7:0] tx_data;
  logic       so, so_oe, cmd_ok, cmd_bad, rx_stb, tx_take;
  logic [7:0] opcode, rx_data;

  int         n_run = 0;
  int         n_fail = 0;
  int         take_cnt = 0;
  string      cur_req = "R3";
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  assign tx_data = tx_base + 8'(take_cnt * 17);

  spi_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .tx_data(tx_data), .spi_so(so), .spi_so_oe(so_oe),
    .opcode(opcode), .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .rx_data(rx_data),
    .rx_stb(rx_stb), .tx_take(tx_take)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (tx_take) take_cnt <= take_cnt + 1;

  // monitor: pop expected bytes as strobes appear
  always @(negedge clk) begin
    if (rst_n && rx_stb) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected rx strobe", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, cur_req, "rx byte", rx_data, e);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic sob, output logic oe);
    si = b;
    wclk(HP);
    sob = so;
    oe  = so_oe;
    sck = 1'b1;
    wclk(HP);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output int oe_n);
    logic sb, oe;
    oe_n = 0;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], sb, oe);
      rx[i] = sb;
      if (oe) oe_n++;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wclk(HP);
  endtask

  task automatic cs_end();
    wclk(HP);
    cs_n = 1'b1;
    wclk(2 * HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic       sb, oe;
    int         oe_n, c0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
    tx_base = 8'h5A;
    wclk(5);
    rst_n = 1'b1;
    wclk(10);

    // R9 reset state
    chk(!so_oe,   "R9", "so_oe after reset",   so_oe,   0);
    chk(!rx_stb,  "R9", "rx_stb after reset",  rx_stb,  0);
    chk(!cmd_ok,  "R9", "cmd_ok after reset",  cmd_ok,  0);
    chk(!cmd_bad, "R9", "cmd_bad after reset", cmd_bad, 0);

    // R1 R2 R3: write with two data bytes
    cur_req = "R3";
    cs_begin();
    spi_byte(8'h02, rb, oe_n);
    chk(opcode == 8'h02, "R2", "opcode write", opcode, 8'h02);
    chk(cmd_ok && !cmd_bad, "R2", "write accepted", {cmd_ok, cmd_bad}, 2'b10);
    exp_q.push_back(8'hA5); spi_byte(8'hA5, rb, oe_n);
    chk(oe_n == 0, "R5", "no oe on write", oe_n, 0);
    exp_q.push_back(8'h3C); spi_byte(8'h3C, rb, oe_n);
    cs_end();

    // R5 memory read, two bytes out
    c0 = take_cnt;
    cs_begin();
    spi_byte(8'h03, rb, oe_n);
    chk(oe_n == 0, "R5", "no oe during code", oe_n, 0);
    exp_q.push_back(8'h00); spi_byte(8'h00, rb, oe_n);
    chk(rb == 8'(8'h5A + c0 * 17), "R5", "read byte 0", rb, 8'(8'h5A + c0 * 17));
    chk(oe_n == 8, "R5", "oe on read byte", oe_n, 8);
    exp_q.push_back(8'hF0); spi_byte(8'hF0, rb, oe_n);
    chk(rb == 8'(8'h5A + (c0 + 1) * 17), "R5", "read byte 1", rb, 8'(8'h5A + (c0 + 1) * 17));
    cs_end();
    chk(!so_oe, "R8", "oe off after deselect", so_oe, 0);

    // R5 status read
    tx_base = 8'h81;
    c0 = take_cnt;
    cs_begin();
    spi_byte(8'h05, rb, oe_n);
    exp_q.push_back(8'h11); spi_byte(8'h11, rb, oe_n);
    chk(rb == 8'(8'h81 + c0 * 17), "R5", "status read byte", rb, 8'(8'h81 + c0 * 17));
    chk(oe_n == 8, "R5", "oe on status read", oe_n, 8);
    cs_end();

    // R2 write-enable, no output
    cs_begin();
    spi_byte(8'h06, rb, oe_n);
    chk(cmd_ok && opcode == 8'h06, "R2", "write enable code", opcode, 8'h06);
    cs_end();

    // R4 unsupported code locks out
    cur_req = "R4";
    cs_begin();
    spi_byte(8'hA7, rb, oe_n);
    chk(cmd_bad && !cmd_ok, "R2", "bad code flagged", {cmd_ok, cmd_bad}, 2'b01);
    spi_byte(8'hFF, rb, oe_n);
    chk(oe_n == 0, "R4", "no oe in lockout", oe_n, 0);
    spi_byte(8'h03, rb, oe_n);
    chk(oe_n == 0, "R4", "read code ignored in lockout", oe_n, 0);
    cs_end();
    cur_req = "R4";
    cs_begin();
    spi_byte(8'h02, rb, oe_n);
    chk(cmd_ok && !cmd_bad, "R4", "next selection decodes", {cmd_ok, cmd_bad}, 2'b10);
    exp_q.push_back(8'h81); spi_byte(8'h81, rb, oe_n);
    cs_end();

    // R6 pause mid-byte during a read
    cur_req = "R6";
    tx_base = 8'hC3;
    c0 = take_cnt;
    cs_begin();
    spi_byte(8'h03, rb, oe_n);
    exp_q.push_back(8'h96);
    for (int i = 7; i >= 4; i--) begin
      spi_bit(1'(8'h96 >> i), sb, oe);
      rb[i] = sb;
    end
    wclk(HP);
    hold_n = 1'b0;
    wclk(HP);
    chk(!so_oe, "R6", "oe low while paused", so_oe, 0);
    for (int k = 0; k < 3; k++) spi_bit(k[0], sb, oe);
    hold_n = 1'b1;
    wclk(HP);
    chk(so_oe, "R6", "oe back after resume", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin
      spi_bit(1'(8'h96 >> i), sb, oe);
      rb[i] = sb;
    end
    chk(rb == 8'(8'hC3 + c0 * 17), "R6", "read byte across pause", rb, 8'(8'hC3 + c0 * 17));
    cs_end();

    // R7 pause input falls while clock high: ignored
    cur_req = "R7";
    cs_begin();
    spi_byte(8'h02, rb, oe_n);
    exp_q.push_back(8'h5B);
    for (int i = 7; i >= 5; i--) spi_bit(1'(8'h5B >> i), sb, oe);
    si = 1'(8'h5B >> 4);
    wclk(HP);
    sck = 1'b1;
    wclk(HP);
    hold_n = 1'b0;
    wclk(HP);
    sck = 1'b0;
    for (int i = 3; i >= 0; i--) spi_bit(1'(8'h5B >> i), sb, oe);
    hold_n = 1'b1;
    exp_q.push_back(8'h24); spi_byte(8'h24, rb, oe_n);
    cs_end();

    // R8 deselected activity is ignored
    cur_req = "R8";
    for (int k = 0; k < 16; k++) spi_bit(k[1], sb, oe);
    wclk(HP);
    chk(opcode == 8'h02, "R8", "opcode kept while deselected", opcode, 8'h02);
    chk(!so_oe, "R8", "oe low while deselected", so_oe, 0);

    // R1 aborted byte then fresh selection
    cur_req = "R1";
    cs_begin();
    for (int k = 0; k < 4; k++) spi_bit(1'b1, sb, oe);
    cs_end();
    cs_begin();
    spi_byte(8'h01, rb, oe_n);
    chk(opcode == 8'h01, "R1", "code after aborted byte", opcode, 8'h01);
    exp_q.push_back(8'h44); spi_byte(8'h44, rb, oe_n);
    cs_end();

    wclk(20);
    chk(exp_q.size() == 0, "R3", "all expected bytes seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule